// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Unit

This block connects a CPU-side memory request port to a 16-bit external data bus. The bus has two byte lanes: the high lane is bits 15..8 and carries the byte at the even address, and the low lane is bits 7..0 and carries the byte at the odd address. Each request carries an address, a byte-or-word size, a read/write flag and write data. The block announces each bus transaction to a bus cycle engine with a one-cycle start pulse. The engine answers with a one-cycle done pulse. Strobe timing, wait states and arbitration all stay inside that engine.

Memory decoded as byte-wide signals this through a narrow input. The block samples that input in the start cycle of a word access. When it is set, the block splits the word into two transactions. Both bytes travel on the low lane: the even byte in the first transaction, and the odd byte in a second transaction addressed with bit 0 set. On reads, the block assembles the two bytes into one word before it returns a response. A byte access never splits.

Top module: `dbs_unit`

## Requirements
- R1: During and right after reset, `busy`, `bus_start` and `rsp_valid` are 0, and both lane enables `bus_hi_en_n` and `bus_lo_en_n` are 1 (inactive).
- R2: A request is accepted at a clock edge where `req_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle until the cycle in which the response pulse appears. A request presented while `busy` is 1 has no effect: it produces no bus transaction and no response.
- R3: `bus_start` pulses for exactly one cycle. The pulse comes in the cycle after acceptance, and again in the cycle after the first done of a split word. The first transaction's address equals the request address with bit 0 cleared for a word, and unchanged for a byte.
- R4: A word access to full-width memory makes one transaction. Both enables are 0. Write data is driven as given (request bits 15..8 on the high lane). Read data returns as the full 16-bit bus word.
- R5: A byte access (`req_word`=0) makes exactly one transaction, whatever `bus_narrow` shows. Only the lane selected by address bit 0 is enabled: bit 0 = 0 gives `bus_hi_en_n`=0 only, and bit 0 = 1 gives `bus_lo_en_n`=0 only. Write data `req_wdata[7:0]` is driven on both lanes. Read data returns in `rsp_rdata[7:0]`, taken from the enabled lane, with `rsp_rdata[15:8]` = 0.
- R6: `bus_narrow` is sampled in the start cycle of a word's first transaction. If it is 1, a second transaction follows in the cycle after the first done. That transaction has the address with bit 0 set, `bus_lo_en_n`=0 and `bus_hi_en_n`=1.
- R7: On a split write, from the cycle after the first start, both lanes carry the even byte (`req_wdata[15:8]`). During the second transaction, both lanes carry the odd byte (`req_wdata[7:0]`).
- R8: On a split read, `rsp_rdata[15:8]` is the low lane of the first transaction and `rsp_rdata[7:0]` is the low lane of the second. No response is given before the second done.
- R9: `rsp_valid` pulses for one cycle, in the cycle after the final done, with `busy` already 0. `rsp_rdata` is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU request present |
| req_addr | input | AW | Request byte address |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (word: bits 15..8 even byte; byte: bits 7..0) |
| busy | output | 1 | Request in progress; new requests stall |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Returned read data |
| bus_start | output | 1 | One-cycle transaction start to the cycle engine |
| bus_addr | output | AW | Transaction address |
| bus_write | output | 1 | Transaction direction |
| bus_hi_en_n | output | 1 | High-lane enable, active low |
| bus_lo_en_n | output | 1 | Low-lane enable, active low |
| bus_wdata | output | 16 | Steered write data |
| bus_narrow | input | 1 | Target memory is byte-wide |
| bus_done | input | 1 | One-cycle transaction completion from the cycle engine |
| bus_rdata | input | 16 | Read data from the bus |

## Verification
The assertions assume a well-behaved cycle engine. It raises `bus_done` exactly once for each `bus_start`, and never in the start cycle itself. It presents `bus_narrow` in that start cycle.

The stimulus plays the engine's role to the same rules. It holds `bus_done` low for a chosen latency after each start, then pulses it once. It drives `bus_narrow` only in start cycles. Every request it makes while `busy` is set is withdrawn before the response cycle.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DW     = 2 * LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_A,
    ST_WAIT_A,
    ST_ISSUE_B,
    ST_WAIT_B
  } seq_state_t;

  // active-low lane enables {hi_n, lo_n}
  function automatic logic [1:0] lane_enables(input logic word, input logic a0,
                                              input logic second);
    if (second)    return 2'b10;
    else if (word) return 2'b00;
    else if (a0)   return 2'b10;
    else           return 2'b01;
  endfunction

  function automatic logic [DW-1:0] steer_wdata(input logic word, input logic second,
                                                input logic narrow_seen,
                                                input logic [DW-1:0] wd);
    logic [LANE_W-1:0] even_b;
    logic [LANE_W-1:0] odd_b;
    even_b = wd[DW-1:LANE_W];
    odd_b  = wd[LANE_W-1:0];
    if (!word || second) return {odd_b, odd_b};
    else if (narrow_seen) return {even_b, even_b};
    else                  return wd;
  endfunction

  function automatic logic [DW-1:0] merge_read(input logic word, input logic a0,
                                               input logic split,
                                               input logic [LANE_W-1:0] first_lo,
                                               input logic [DW-1:0] rd);
    if (!word)      return {{LANE_W{1'b0}}, (a0 ? rd[LANE_W-1:0] : rd[DW-1:LANE_W])};
    else if (split) return {first_lo, rd[LANE_W-1:0]};
    else            return rd;
  endfunction
endpackage

// File: rtl/dbs_req_hold.sv
module dbs_req_hold #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] in_addr,
  input  logic          in_word,
  input  logic          in_write,
  input  logic [DW-1:0] in_wdata,
  output logic [AW-1:0] addr_q,
  output logic          word_q,
  output logic          write_q,
  output logic [DW-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      word_q  <= in_word;
      write_q <= in_write;
      wdata_q <= in_wdata;
    end
  end
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       word_q,
  input  logic       narrow_in,
  input  logic       done_in,
  output logic       active,
  output logic       start,
  output logic       phase_b,
  output logic       narrow_seen,
  output logic       split_evt,
  output logic       fin_evt
);
  seq_state_t state_q;
  seq_state_t state_d;
  logic       narrow_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_ISSUE_A;
      ST_ISSUE_A: state_d = ST_WAIT_A;
      ST_WAIT_A:  if (done_in) state_d = narrow_q ? ST_ISSUE_B : ST_IDLE;
      ST_ISSUE_B: state_d = ST_WAIT_B;
      ST_WAIT_B:  if (done_in) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      narrow_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_ISSUE_A) narrow_q <= word_q & narrow_in;
      else if (state_q == ST_IDLE) narrow_q <= 1'b0;
    end
  end

  assign active      = (state_q != ST_IDLE);
  assign start       = (state_q == ST_ISSUE_A) || (state_q == ST_ISSUE_B);
  assign phase_b     = (state_q == ST_ISSUE_B) || (state_q == ST_WAIT_B);
  assign narrow_seen = narrow_q;
  assign split_evt   = done_in && (state_q == ST_WAIT_A) && narrow_q;
  assign fin_evt     = done_in && (((state_q == ST_WAIT_A) && !narrow_q) ||
                                   (state_q == ST_WAIT_B));
endmodule

// File: rtl/dbs_lane_steer.sv
module dbs_lane_steer
  import dbs_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          active,
  input  logic          phase_b,
  input  logic          narrow_seen,
  input  logic [AW-1:0] addr_q,
  input  logic          word_q,
  input  logic          write_q,
  input  logic [DW-1:0] wdata_q,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic [1:0]    en_n,
  output logic [DW-1:0] bus_wdata
);
  function automatic logic [AW-1:0] txn_addr(input logic [AW-1:0] a, input logic word,
                                             input logic second);
    if (second)    return {a[AW-1:1], 1'b1};
    else if (word) return {a[AW-1:1], 1'b0};
    else           return a;
  endfunction

  always_comb begin
    bus_addr  = txn_addr(addr_q, word_q, phase_b);
    bus_write = active & write_q;
    en_n      = active ? lane_enables(word_q, addr_q[0], phase_b) : 2'b11;
    bus_wdata = steer_wdata(word_q, phase_b, narrow_seen, wdata_q);
  end
endmodule

// File: rtl/dbs_read_asm.sv
module dbs_read_asm
  import dbs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          split_evt,
  input  logic          fin_evt,
  input  logic          word_q,
  input  logic          a0_q,
  input  logic          write_q,
  input  logic          narrow_seen,
  input  logic [DW-1:0] bus_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic [LANE_W-1:0] first_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_lo_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (split_evt) first_lo_q <= bus_rdata[LANE_W-1:0];
      rsp_valid <= fin_evt;
      if (fin_evt)
        rsp_rdata <= write_q ? '0 :
                     merge_read(word_q, a0_q, narrow_seen, first_lo_q, bus_rdata);
    end
  end
endmodule

// File: rtl/dbs_unit.sv
module dbs_unit
  import dbs_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic          req_write,
  input  logic [15:0]   req_wdata,
  output logic          busy,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic          bus_start,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          bus_hi_en_n,
  output logic          bus_lo_en_n,
  output logic [15:0]   bus_wdata,
  input  logic          bus_narrow,
  input  logic          bus_done,
  input  logic [15:0]   bus_rdata
);
  logic          accept_evt;
  logic          split_evt;
  logic          fin_evt;
  logic          active;
  logic          phase_b;
  logic          narrow_seen;
  logic [AW-1:0] addr_q;
  logic          word_q;
  logic          write_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    en_n;

  assign accept_evt = req_valid && !active;
  assign busy       = active;

  dbs_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .accept(accept_evt),
    .in_addr(req_addr), .in_word(req_word), .in_write(req_write), .in_wdata(req_wdata),
    .addr_q(addr_q), .word_q(word_q), .write_q(write_q), .wdata_q(wdata_q)
  );

  dbs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept_evt), .word_q(word_q),
    .narrow_in(bus_narrow), .done_in(bus_done),
    .active(active), .start(bus_start), .phase_b(phase_b),
    .narrow_seen(narrow_seen), .split_evt(split_evt), .fin_evt(fin_evt)
  );

  dbs_lane_steer #(.AW(AW)) u_steer (
    .active(active), .phase_b(phase_b), .narrow_seen(narrow_seen),
    .addr_q(addr_q), .word_q(word_q), .write_q(write_q), .wdata_q(wdata_q),
    .bus_addr(bus_addr), .bus_write(bus_write), .en_n(en_n), .bus_wdata(bus_wdata)
  );

  assign bus_hi_en_n = en_n[1];
  assign bus_lo_en_n = en_n[0];

  dbs_read_asm u_asm (
    .clk(clk), .rst_n(rst_n), .split_evt(split_evt), .fin_evt(fin_evt),
    .word_q(word_q), .a0_q(addr_q[0]), .write_q(write_q), .narrow_seen(narrow_seen),
    .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/dbs_unit_chk.sv
module dbs_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          rsp_valid,
  input logic          bus_start,
  input logic [AW-1:0] bus_addr,
  input logic          bus_hi_en_n,
  input logic          bus_lo_en_n,
  input logic          phase_b,
  input logic          split_evt,
  input logic          fin_evt
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_hi_en_n && bus_lo_en_n && !bus_start));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);

  // R5
  some_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> !(bus_hi_en_n && bus_lo_en_n));

  // R6
  second_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && phase_b) |-> (bus_addr[0] && bus_hi_en_n && !bus_lo_en_n));

  // R6
  split_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_evt |=> (bus_start && busy));

  // R9
  rsp_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> (rsp_valid && !busy));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind dbs_unit dbs_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rsp_valid(rsp_valid), .bus_start(bus_start), .bus_addr(bus_addr),
  .bus_hi_en_n(bus_hi_en_n), .bus_lo_en_n(bus_lo_en_n), .phase_b(phase_b),
  .split_evt(split_evt), .fin_evt(fin_evt)
);

// File: tb/tb_dbs_unit.sv
module tb_dbs_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_word = 1'b0;
  logic          req_write = 1'b0;
  logic [15:0]   req_wdata = '0;
  logic          busy;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic          bus_start;
  logic [AW-1:0] bus_addr;
  logic          bus_write;
  logic          bus_hi_en_n;
  logic          bus_lo_en_n;
  logic [15:0]   bus_wdata;
  logic          bus_narrow = 1'b0;
  logic          bus_done = 1'b0;
  logic [15:0]   bus_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbs_unit #(.AW(AW)) dut (.*);

  // behavioural memory contents: one byte per address
  function automatic logic [7:0] mem_at(input logic [AW-1:0] a);
    return 8'(a[7:0] * 8'd7 + 8'd3);
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_req(input logic [AW-1:0] a, input bit word, input bit wr,
                        input logic [15:0] wd, input bit narrow, input int lat,
                        input bit poke);
    logic [AW-1:0] base;
    logic [1:0]    exp_en;
    logic [15:0]   exp_wd;
    logic [15:0]   exp_rd;
    bit            split;
    split  = word && narrow;
    base   = word ? {a[AW-1:1], 1'b0} : a;
    exp_en = word ? 2'b00 : (a[0] ? 2'b10 : 2'b01);
    @(negedge clk);
    chk("R2 idle before request", busy, 0);
    req_valid = 1'b1; req_addr = a; req_word = word; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 start after accept", bus_start, 1);
    chk("R3 first address", bus_addr, base);
    chk("R2 busy after accept", busy, 1);
    chk(word ? "R4 word enables" : "R5 byte enables", {bus_hi_en_n, bus_lo_en_n}, exp_en);
    chk("R2 direction", bus_write, wr);
    bus_narrow = narrow;
    @(negedge clk);
    bus_narrow = 1'b0;
    chk("R3 start single cycle", bus_start, 0);
    if (wr) begin
      exp_wd = !word ? {wd[7:0], wd[7:0]} : (narrow ? {wd[15:8], wd[15:8]} : wd);
      chk(!word ? "R5 byte write lanes" : (narrow ? "R7 split first lanes" : "R4 word write"),
          bus_wdata, exp_wd);
    end
    if (poke) begin
      req_valid = 1'b1; req_addr = a ^ 32'h40; req_word = ~word;
    end
    for (int i = 0; i < lat; i++) begin
      chk("R2 busy while waiting", busy, 1);
      chk("R2 no extra start", bus_start, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    bus_done = 1'b1;
    if (split)      bus_rdata = {8'hEE, mem_at(bus_addr)};
    else if (word)  bus_rdata = {mem_at(bus_addr), mem_at(bus_addr | 1)};
    else if (a[0])  bus_rdata = {8'hEE, mem_at(bus_addr)};
    else            bus_rdata = {mem_at(bus_addr), 8'hEE};
    @(negedge clk);
    bus_done = 1'b0;
    if (split) begin
      chk("R8 no early response", rsp_valid, 0);
      chk("R6 second start", bus_start, 1);
      chk("R6 second address", bus_addr, base | 1);
      chk("R6 second enables", {bus_hi_en_n, bus_lo_en_n}, 2'b10);
      @(negedge clk);
      if (wr) chk("R7 split second lanes", bus_wdata, {wd[7:0], wd[7:0]});
      bus_done = 1'b1;
      bus_rdata = {8'hEE, mem_at(bus_addr)};
      @(negedge clk);
      bus_done = 1'b0;
    end else begin
      chk(word ? "R4 single transaction" : "R5 no split", bus_start, 0);
    end
    chk("R9 response pulse", rsp_valid, 1);
    chk("R9 busy clear at response", busy, 0);
    exp_rd = wr ? 16'h0 : (word ? {mem_at(base), mem_at(base | 1)} : {8'h00, mem_at(a)});
    chk(wr ? "R9 write rdata" : (split ? "R8 split read data" :
        (word ? "R4 word read data" : "R5 byte read data")), rsp_rdata, exp_rd);
    @(negedge clk);
    chk("R9 pulse ends", rsp_valid, 0);
    chk("R2 ignored request made no start", bus_start, 0);
    chk("R2 idle after response", busy, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 start in reset", bus_start, 0);
    chk("R1 enables in reset", {bus_hi_en_n, bus_lo_en_n}, 2'b11);
    chk("R1 rsp in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 quiet after reset", {busy, bus_start, rsp_valid}, 0);
    do_req(32'h0000_1010, 1, 0, 16'h0, 0, 2, 0);
    do_req(32'h0000_2020, 1, 0, 16'h0, 1, 1, 0);
    do_req(32'h0000_3031, 1, 0, 16'h0, 1, 0, 0);
    do_req(32'h0000_4040, 1, 1, 16'hA55A, 0, 1, 0);
    do_req(32'h0000_5050, 1, 1, 16'hC3B4, 1, 3, 1);
    do_req(32'h0000_6060, 0, 0, 16'h0, 0, 1, 0);
    do_req(32'h0000_6061, 0, 0, 16'h0, 0, 0, 0);
    do_req(32'h0000_7071, 0, 0, 16'h0, 1, 2, 0);
    do_req(32'h0000_8080, 0, 1, 16'h0077, 1, 1, 0);
    do_req(32'h0000_9091, 0, 1, 16'h00E1, 0, 2, 1);
    do_req(32'h0000_A0A0, 1, 0, 16'h0, 0, 4, 1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule